// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Generator

This block produces the internal word address of a synchronous burst memory. An external address is captured when either of two active-low address strobes starts a burst. From then on the low two bits are stepped internally on every clock in which the active-low advance input is asserted, giving a four-beat burst. The upper address bits are frozen for the whole burst.

A run-time mode input chooses between two step orders. In linear order the beat count is added to the loaded low bits modulo 4. In interleaved order the beat count is XORed into the loaded low bits. Further advances past the fourth beat wrap inside the same four-word block. A new address may be loaded on every cycle with no gap between loads.

The two strobes follow different gating rules. The controller-side strobe is honoured only while chip enable is active. The memory-side strobe loads on its own, whatever chip enable and the other strobe are doing.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset (rst_n low, synchronous), addr_out is 0.
- R2: When strobe_mem_n is 0 at a rising edge, addr_out equals the sampled addr_in after that edge, regardless of ce_n and strobe_ctl_n.
- R3: When strobe_ctl_n is 0 and ce_n is 0 at a rising edge, addr_out equals the sampled addr_in after that edge. When ce_n is 1 and strobe_mem_n is 1, strobe_ctl_n has no effect on addr_out.
- R4: With no load, adv_n = 0 at a rising edge advances the beat count by one. adv_n = 1 leaves addr_out unchanged.
- R5: With mode_lin = 1, addr_out[1:0] = (loaded addr[1:0] + beat) mod 4.
- R6: With mode_lin = 0, or with mode_lin left undriven, addr_out[1:0] = loaded addr[1:0] XOR beat.
- R7: addr_out bits above bit 1 change only on a load. Beats past the fourth wrap within the same four-word block.
- R8: A load in the same cycle as adv_n = 0 takes priority and restarts the burst at beat 0.
- R9: Loads on consecutive cycles each take effect, one per edge, with no lost address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address to load |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low, gated by ce_n |
| strobe_mem_n | input | 1 | Memory-side address strobe, active low, ungated |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| mode_lin | input | 1 | 1 selects linear order; 0 or undriven selects interleaved |
| addr_out | output | ADDR_W | Current internal word address |

## Verification
The hardest case to reach is a wrap past the fourth beat from every possible starting offset in both orders. A wrong order is hidden on short bursts, and a carry into the upper bits shows only when the low bits roll over. The bench therefore loads each of the four starting offsets under several upper-bit patterns in both modes. It advances seven beats with stall cycles mixed in and computes each expected address arithmetically. It then chains loads on consecutive edges and puts loads in the same cycle as advances, which exercises the priority and back-to-back paths.

// File: rtl/burst_pkg.sv
// Package: shared widths and helpers for the burst address generator.
// Assumes a four-beat burst, so the beat counter is two bits wide.
package burst_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;

    // Linear step: add beat to base modulo the burst length.
    function automatic beat_t lin_step(input beat_t base, input beat_t beat);
        return beat_t'(base + beat);
    endfunction

    // Interleaved step: XOR beat into base.
    function automatic beat_t ilv_step(input beat_t base, input beat_t beat);
        return base ^ beat;
    endfunction
endpackage

// File: rtl/burst_load_ctl.sv
// Load/advance decision logic.
// Assumes all strobes, advance and chip enable are active low. A load
// outranks an advance, and the memory-side strobe ignores chip enable.
module burst_load_ctl (
    input  logic strobe_ctl_n,
    input  logic strobe_mem_n,
    input  logic adv_n,
    input  logic ce_n,
    output logic load,
    output logic step
);
    // Decide whether this edge loads a new address or steps the beat.
    always_comb begin
        load = !strobe_mem_n || (!strobe_ctl_n && !ce_n);
        step = !load && !adv_n;
    end
endmodule

// File: rtl/burst_state_reg.sv
// Holds the captured base address and the running beat count.
// Assumes a synchronous active-low reset. The beat counter wraps freely.
module burst_state_reg #(
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [ADDR_W-1:0]         addr_in,
    output logic [ADDR_W-1:0]         base_q,
    output logic [burst_pkg::BEAT_W-1:0] beat_q
);
    import burst_pkg::*;

    // Capture the base on load; count beats on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Maps base low bits and beat count to the output low bits.
// Assumes mode_lin = 1 means linear. Any other value, including X or Z in
// simulation, falls to the interleaved branch.
module burst_order_map (
    input  logic [burst_pkg::BEAT_W-1:0] base_lo,
    input  logic [burst_pkg::BEAT_W-1:0] beat,
    input  logic                         mode_lin,
    output logic [burst_pkg::BEAT_W-1:0] lo_out
);
    import burst_pkg::*;

    // Choose the step order for the current beat.
    always_comb begin
        if (mode_lin) lo_out = lin_step(base_lo, beat);
        else          lo_out = ilv_step(base_lo, beat);
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Top: burst address generator for a synchronous burst memory.
// Assumes ADDR_W > BEAT_W. Only the low BEAT_W bits are burst-stepped and
// the upper bits hold the loaded value.
module burst_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_ctl_n,
    input  logic              strobe_mem_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              mode_lin,
    output logic [ADDR_W-1:0] addr_out
);
    import burst_pkg::*;
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] base_q;
    beat_t             beat_q;
    beat_t             lo_out;

    burst_load_ctl u_ctl (
        .strobe_ctl_n (strobe_ctl_n),
        .strobe_mem_n (strobe_mem_n),
        .adv_n        (adv_n),
        .ce_n         (ce_n),
        .load         (load),
        .step         (step)
    );

    burst_state_reg #(.ADDR_W(ADDR_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_order_map u_map (
        .base_lo  (base_q[BEAT_W-1:0]),
        .beat     (beat_q),
        .mode_lin (mode_lin),
        .lo_out   (lo_out)
    );

    // Join the frozen upper bits with the stepped low bits.
    always_comb begin
        addr_out = {base_q[ADDR_W-1 -: HI_W], lo_out};
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen, bound to every instance.
// Assumes it observes only top-level ports.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_ctl_n,
    input logic              strobe_mem_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              mode_lin,
    input logic [ADDR_W-1:0] addr_out
);
    logic no_load;
    assign no_load = strobe_mem_n && (strobe_ctl_n || ce_n);

    // R2, R8: memory-side strobe loads, even alongside an advance
    a_r2_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_mem_n |=> addr_out == $past(addr_in));

    // R3: gated controller strobe loads
    a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && !ce_n) |=> addr_out == $past(addr_in));

    // R7: upper bits hold without a load
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        no_load |=> $stable(addr_out[ADDR_W-1:2]));

    // R4: no advance and no mode change keeps the output
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && adv_n) |=> (mode_lin != $past(mode_lin)) || $stable(addr_out));

    // R5: a linear advance adds one modulo 4
    a_r5_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && !adv_n && mode_lin) |=>
        (!mode_lin) || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_ctl_n = 1;
    logic          strobe_mem_n = 1;
    logic          adv_n = 1;
    logic          ce_n = 1;
    logic          mode_lin = 0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int failures = 0;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count one check; print a failure line on mismatch.
    task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Apply inputs, pass one rising edge, then wait for the falling edge.
    task automatic cyc(input logic mem_n, input logic ctl_n, input logic ce,
                       input logic adv, input logic [AW-1:0] a);
        strobe_mem_n = mem_n; strobe_ctl_n = ctl_n; ce_n = ce; adv_n = adv; addr_in = a;
        @(posedge clk); @(negedge clk);
        strobe_mem_n = 1; strobe_ctl_n = 1; adv_n = 1;
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b, input int beat, input logic lin);
        logic [1:0] lo;
        if (lin) lo = 2'((b[1:0] + beat) % 4);
        else     lo = b[1:0] ^ 2'(beat % 4);
        return {b[AW-1:2], lo};
    endfunction

    initial begin
        #(CLK_PERIOD*100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        int beat;
        @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R1 reset", addr_out, '0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", addr_out, '0);

        // Sweep over modes, start offsets and upper patterns (R5 R6 R7 R4 R2)
        for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 4; u++) begin
                for (int s = 0; s < 4; s++) begin
                    mode_lin = m[0];
                    base = {6'(u * 6'h15 + 1), 2'(s)};
                    cyc(0, 1, 1, 1, base);
                    chk("R2 load", addr_out, base);
                    beat = 0;
                    for (int k = 0; k < 7; k++) begin
                        cyc(1, 1, 0, 0, 8'hff);
                        beat++;
                        chk(m ? "R5 R7 linear step" : "R6 R7 interleaved step",
                            addr_out, expect_addr(base, beat, m[0]));
                        if (k == 2) begin
                            cyc(1, 1, 0, 1, 8'h00);
                            chk("R4 hold", addr_out, expect_addr(base, beat, m[0]));
                        end
                    end
                end
            end
        end

        // Gated controller strobe (R3)
        mode_lin = 1;
        cyc(0, 1, 1, 1, 8'h40);
        cyc(1, 0, 1, 1, 8'h9b);
        chk("R3 ce inactive ignored", addr_out, 8'h40);
        cyc(1, 0, 0, 1, 8'h9b);
        chk("R3 ce active load", addr_out, 8'h9b);
        cyc(0, 1, 1, 1, 8'h3e);
        chk("R2 ignores ce", addr_out, 8'h3e);

        // Load beats advance (R8)
        cyc(1, 1, 0, 0, 8'h00);
        chk("R8 pre step", addr_out, 8'h3f);
        cyc(0, 1, 1, 0, 8'h71);
        chk("R8 mem load priority", addr_out, 8'h71);
        cyc(1, 0, 0, 0, 8'h86);
        chk("R8 ctl load priority", addr_out, 8'h86);

        // Back-to-back loads (R9)
        for (int i = 0; i < 12; i++) begin
            logic [AW-1:0] a;
            a = AW'(i * 37 + 11);
            if (i % 2 == 0) cyc(0, 1, 1, i % 3 == 0, a);
            else            cyc(1, 0, 0, 0, a);
            chk("R9 consecutive load", addr_out, a);
        end

        // Undriven mode falls to interleaved (R6)
        mode_lin = 1'bz;
        cyc(0, 1, 1, 1, 8'h52);
        cyc(1, 1, 0, 0, 8'h00);
        cyc(1, 1, 0, 0, 8'h00);
        cyc(1, 1, 0, 0, 8'h00);
        chk("R6 undriven interleaved", addr_out, 8'h51);
        mode_lin = 0;

        // Reset mid-burst (R1)
        rst_n = 0;
        cyc(1, 1, 0, 0, 8'h00);
        chk("R1 reset mid burst", addr_out, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule